// File: doc/BRIEF.md
# Hardwired Step-Sequenced Instruction Controller

This block is the control unit of a single-bus processor whose datapath is built elsewhere. A step counter runs through time slots T1 to T7, one slot per clock. A step decoder turns the count into a one-hot set of slots, and an instruction decoder turns the 4-bit opcode into a one-hot set of instruction lines. Fixed sum-of-products terms combine the slots, the instruction lines and the N status flag into the gating strobes for the datapath. Each strobe either drives a register onto the shared bus, loads a register from the bus, or controls the memory or the ALU.

Slots T1 to T3 fetch an instruction for every opcode. Later slots depend on the opcode: an add whose operand is fetched from memory, an unconditional relative branch, a branch taken on the N flag, and a fallback for unknown opcodes. The counter stops while the datapath waits for memory, and it stops again whenever `run` is low. When `end_pulse` is asserted, the next slot is T1. Because the end term includes the N flag, a branch that is not taken finishes two slots early.

The counter has seven named states, S1 to S7, one for each slot T1 to T7. With `run` high, each state moves to the next one (S1→S2→…→S7→S1). The counter stays in its state on a memory wait or when `run` is low. From any state, an `end_pulse` returns the counter to S1.

Top module: `step_ctrl_unit`

## Requirements
- R1: While `rst_n` is low the counter is in S1. After reset is released with `run` high, the first slot shows the T1 fetch strobes.
- R2: Fetch, for every opcode. T1 asserts `pc_drive`, `mar_load`, `mem_rd`, `carry_set`, `alu_add` and `z_load`. T2 asserts `z_drive`, `pc_load` and `wait_done`. T3 asserts `mdr_drive` and `ir_load`.
- R3: While `wait_done` is high and `mem_done` is low, the slot does not advance and the strobes stay as they are. The slot advances on the first clock with `mem_done` high.
- R4: Opcode 4'h1 (add from memory) runs four execution slots. T4 asserts `reg_drive`, `mar_load` and `mem_rd`. T5 asserts `reg_drive`, `y_load` and `wait_done`. T6 asserts `mdr_drive`, `alu_add` and `z_load`. T7 asserts `z_drive`, `reg_load` and `end_pulse`.
- R5: Opcode 4'h2 (unconditional branch) runs three execution slots. T4 asserts `pc_drive` and `y_load`. T5 asserts `off_drive`, `alu_add` and `z_load`. T6 asserts `z_drive`, `pc_load` and `end_pulse`.
- R6: Opcode 4'h3 (branch on N) uses the same strobes as R5. When `flag_n`=0, `end_pulse` is asserted in T4. When `flag_n`=1, `end_pulse` is asserted in T6.
- R7: Any other opcode asserts only `end_pulse` in T4.
- R8: While `run` is low, every output is 0 and the slot is held. When `run` goes high again, execution resumes in the same slot.
- R9: In the slot after any cycle with `end_pulse` high, with `run` high, the T1 fetch strobes are shown.
- R10: In any cycle, at most one of `pc_drive`, `z_drive`, `mdr_drive`, `reg_drive` and `off_drive` is high.
- R11: `z_load` is high only in T1, in T6 for the add, and in T5 for either branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables stepping and the strobes |
| opcode | input | 4 | Opcode field of the instruction register |
| flag_n | input | 1 | N status flag |
| mem_done | input | 1 | Memory access complete |
| pc_drive | output | 1 | PC onto bus |
| pc_load | output | 1 | Load PC from bus |
| mar_load | output | 1 | Load memory address register |
| mem_rd | output | 1 | Start memory read |
| carry_set | output | 1 | ALU carry-in set |
| alu_add | output | 1 | ALU function add |
| z_load | output | 1 | Load ALU result register Z |
| z_drive | output | 1 | Z onto bus |
| mdr_drive | output | 1 | Memory data register onto bus |
| ir_load | output | 1 | Load instruction register |
| y_load | output | 1 | Load ALU operand register Y |
| reg_drive | output | 1 | Register file onto bus |
| reg_load | output | 1 | Load register file from bus |
| off_drive | output | 1 | IR offset field onto bus |
| wait_done | output | 1 | Wait for memory completion |
| end_pulse | output | 1 | Last slot of the instruction |

## Verification
The assertions check the cycle-level invariants on every clock. These are the single bus driver, the return to fetch after an end, the hold while memory is not done, the quiet outputs while stopped, and the slots in which Z may load. Only the bench scenarios can show that each opcode produces the right strobes in the right slot. The same holds for the early finish of an untaken branch, a correct resume after a pause in `run`, and stalls of several cycles at both wait slots. For these, the bench compares every output against its own step model on each cycle.

// File: rtl/step_ctrl_pkg.sv
package step_ctrl_pkg;
    localparam int OPC_W     = 4;
    localparam int NUM_STEPS = 7;
    localparam int STEP_W    = $clog2(NUM_STEPS);

    typedef enum logic [STEP_W-1:0] {
        S1 = 3'd0, S2 = 3'd1, S3 = 3'd2, S4 = 3'd3,
        S5 = 3'd4, S6 = 3'd5, S7 = 3'd6
    } step_e;

    localparam logic [OPC_W-1:0] OPC_ADDM = 4'h1;
    localparam logic [OPC_W-1:0] OPC_JMP  = 4'h2;
    localparam logic [OPC_W-1:0] OPC_JN   = 4'h3;

    typedef struct packed {
        logic addm;
        logic jmp;
        logic jn;
        logic other;
    } ins_t;
endpackage

// File: rtl/step_counter.sv
module step_counter
    import step_ctrl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  end_now,
    input  logic  hold,
    output step_e step
);
    step_e step_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step <= S1;
        else        step <= step_nx;
    end

    always_comb begin
        step_nx = step;
        if (run) begin
            if (end_now) begin
                step_nx = S1;
            end else if (!hold) begin
                unique case (step)
                    S1: step_nx = S2;
                    S2: step_nx = S3;
                    S3: step_nx = S4;
                    S4: step_nx = S5;
                    S5: step_nx = S6;
                    S6: step_nx = S7;
                    S7: step_nx = S1;
                    default: step_nx = S1;
                endcase
            end
        end
    end
endmodule

// File: rtl/step_decoder.sv
module step_decoder
    import step_ctrl_pkg::*;
(
    input  step_e                step,
    output logic [NUM_STEPS-1:0] slot
);
    for (genvar i = 0; i < NUM_STEPS; i++) begin : g_slot
        assign slot[i] = (step == step_e'(i));
    end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import step_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output ins_t             ins
);
    always_comb begin
        ins = '0;
        unique case (opcode)
            OPC_ADDM: ins.addm  = 1'b1;
            OPC_JMP:  ins.jmp   = 1'b1;
            OPC_JN:   ins.jn    = 1'b1;
            default:  ins.other = 1'b1;
        endcase
    end
endmodule

// File: rtl/step_ctrl_unit.sv
module step_ctrl_unit
    import step_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [OPC_W-1:0] opcode,
    input  logic             flag_n,
    input  logic             mem_done,
    output logic             pc_drive,
    output logic             pc_load,
    output logic             mar_load,
    output logic             mem_rd,
    output logic             carry_set,
    output logic             alu_add,
    output logic             z_load,
    output logic             z_drive,
    output logic             mdr_drive,
    output logic             ir_load,
    output logic             y_load,
    output logic             reg_drive,
    output logic             reg_load,
    output logic             off_drive,
    output logic             wait_done,
    output logic             end_pulse
);
    step_e                step;
    logic [NUM_STEPS-1:0] t;
    ins_t                 ins;
    logic                 br_any;
    logic                 hold;

    step_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .end_now (end_pulse),
        .hold    (hold),
        .step    (step)
    );

    step_decoder u_sdec (.step(step), .slot(t));
    instr_decoder u_idec (.opcode(opcode), .ins(ins));

    assign br_any = ins.jmp | ins.jn;
    assign hold   = wait_done & ~mem_done;

    // Sum-of-products encoder, gated by run
    always_comb begin
        pc_drive  = run & (t[0] | (t[3] & br_any));
        pc_load   = run & (t[1] | (t[5] & br_any));
        mar_load  = run & (t[0] | (t[3] & ins.addm));
        mem_rd    = run & (t[0] | (t[3] & ins.addm));
        carry_set = run & t[0];
        alu_add   = run & (t[0] | (t[5] & ins.addm) | (t[4] & br_any));
        z_load    = run & (t[0] | (t[5] & ins.addm) | (t[4] & br_any));
        z_drive   = run & (t[1] | (t[6] & ins.addm) | (t[5] & br_any));
        mdr_drive = run & (t[2] | (t[5] & ins.addm));
        ir_load   = run & t[2];
        y_load    = run & ((t[4] & ins.addm) | (t[3] & br_any));
        reg_drive = run & ((t[3] | t[4]) & ins.addm);
        reg_load  = run & t[6] & ins.addm;
        off_drive = run & t[4] & br_any;
        wait_done = run & (t[1] | (t[4] & ins.addm));
        end_pulse = run & ((t[6] & ins.addm) | (t[5] & ins.jmp)
                         | (((t[5] & flag_n) | (t[3] & ~flag_n)) & ins.jn)
                         | (t[3] & ins.other));
    end
endmodule

// File: rtl/step_ctrl_chk.sv
module step_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic mem_done,
    input logic pc_drive,
    input logic pc_load,
    input logic mar_load,
    input logic mem_rd,
    input logic carry_set,
    input logic alu_add,
    input logic z_load,
    input logic z_drive,
    input logic mdr_drive,
    input logic ir_load,
    input logic y_load,
    input logic reg_drive,
    input logic reg_load,
    input logic off_drive,
    input logic wait_done,
    input logic end_pulse
);
    // R10
    bus_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pc_drive, z_drive, mdr_drive, reg_drive, off_drive}) <= 1);

    // R9
    end_to_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |=> (!run || (pc_drive && carry_set && !wait_done)));

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_done && !mem_done) |=> (!run || wait_done));

    // R8
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> ({pc_drive, pc_load, mar_load, mem_rd, carry_set, alu_add,
                   z_load, z_drive, mdr_drive, ir_load, y_load, reg_drive,
                   reg_load, off_drive, wait_done, end_pulse} == '0));

    // R11
    z_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        z_load |-> (carry_set || mdr_drive || off_drive));

    // R2
    fetch_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |-> (mdr_drive && !end_pulse));
endmodule

bind step_ctrl_unit step_ctrl_chk u_chk (.*);

// File: tb/step_ctrl_unit_tb.sv
`timescale 1ns/1ps
module step_ctrl_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic [3:0] opcode = 4'h0;
    logic flag_n = 1'b0;
    logic mem_done = 1'b0;
    logic pc_drive, pc_load, mar_load, mem_rd, carry_set, alu_add, z_load;
    logic z_drive, mdr_drive, ir_load, y_load, reg_drive, reg_load;
    logic off_drive, wait_done, end_pulse;

    int checks = 0;
    int errors = 0;
    int mstep = 1;
    bit finished = 0;

    always #2 clk = ~clk;

    step_ctrl_unit u_dut (.*);

    wire [15:0] act = {pc_drive, pc_load, mar_load, mem_rd, carry_set, alu_add,
                       z_load, z_drive, mdr_drive, ir_load, y_load, reg_drive,
                       reg_load, off_drive, wait_done, end_pulse};

    // bit positions in the packed word
    localparam int PCD = 15, PCL = 14, MAR = 13, RD = 12, CIN = 11, ADD = 10;
    localparam int ZL = 9, ZD = 8, MDR = 7, IRL = 6, YL = 5, RGD = 4;
    localparam int RGL = 3, OFF = 2, WT = 1, EN = 0;

    function automatic logic [15:0] model(int s, logic r, logic [3:0] o, logic n);
        logic [15:0] w = '0;
        if (!r) return w;
        case (s)
            1: begin w[PCD]=1; w[MAR]=1; w[RD]=1; w[CIN]=1; w[ADD]=1; w[ZL]=1; end
            2: begin w[ZD]=1; w[PCL]=1; w[WT]=1; end
            3: begin w[MDR]=1; w[IRL]=1; end
            default: begin
                if (o == 4'h1) begin
                    if (s == 4) begin w[RGD]=1; w[MAR]=1; w[RD]=1; end
                    if (s == 5) begin w[RGD]=1; w[YL]=1; w[WT]=1; end
                    if (s == 6) begin w[MDR]=1; w[ADD]=1; w[ZL]=1; end
                    if (s == 7) begin w[ZD]=1; w[RGL]=1; w[EN]=1; end
                end else if (o == 4'h2 || o == 4'h3) begin
                    if (s == 4) begin w[PCD]=1; w[YL]=1; if (o == 4'h3 && !n) w[EN]=1; end
                    if (s == 5) begin w[OFF]=1; w[ADD]=1; w[ZL]=1; end
                    if (s == 6) begin w[ZD]=1; w[PCL]=1; w[EN]=1; end
                end else if (s == 4) begin
                    w[EN] = 1;
                end
            end
        endcase
        return w;
    endfunction

    task automatic cyc(input logic r, input logic [3:0] o, input logic n,
                       input logic d, input string tag);
        logic [15:0] exp;
        run = r; opcode = o; flag_n = n; mem_done = d;
        #1;
        exp = model(rst_n ? mstep : 1, r, o, n);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s step=%0d actual=%b expected=%b", tag, mstep, act, exp);
        end
        if (!rst_n) mstep = 1;
        else if (r) begin
            if (exp[EN]) mstep = 1;
            else if (!(exp[WT] && !d)) mstep = (mstep == 7) ? 1 : mstep + 1;
        end
        @(negedge clk);
    endtask

    // One instruction; stall cycles at every wait slot
    task automatic instr(input logic [3:0] o, input logic n, input int stall,
                         input string tag);
        int waited = 0;
        for (int k = 0; k < 30; k++) begin
            logic [15:0] e = model(mstep, 1'b1, o, n);
            logic d = 1'b1;
            if (e[WT]) begin
                d = (waited >= stall);
                waited = d ? 0 : waited + 1;
            end
            cyc(1'b1, o, n, d, tag);
            if (e[EN]) break;
        end
    endtask

    initial begin
        @(negedge clk);
        cyc(1'b0, 4'h0, 1'b0, 1'b0, "R1 reset quiet");
        cyc(1'b1, 4'h1, 1'b0, 1'b0, "R1 reset");
        rst_n = 1'b1;
        instr(4'h1, 1'b0, 0, "R1 R2 R4 add");
        instr(4'h1, 1'b0, 3, "R3 R4 add stalled");
        instr(4'h2, 1'b0, 2, "R5 R11 branch");
        instr(4'h3, 1'b0, 0, "R6 branch N=0");
        instr(4'h3, 1'b1, 1, "R6 branch N=1");
        instr(4'hF, 1'b1, 0, "R7 unknown");
        instr(4'h0, 1'b0, 0, "R7 unknown zero");
        // pause mid-instruction
        cyc(1'b1, 4'h1, 1'b0, 1'b1, "R8 pre");
        cyc(1'b1, 4'h1, 1'b0, 1'b1, "R8 pre");
        cyc(1'b1, 4'h1, 1'b0, 1'b1, "R8 pre");
        cyc(1'b1, 4'h1, 1'b0, 1'b1, "R8 pre");
        for (int k = 0; k < 3; k++) cyc(1'b0, 4'h1, 1'b0, 1'b1, "R8 stopped");
        instr(4'h1, 1'b0, 1, "R8 R9 resume");
        instr(4'h3, 1'b0, 0, "R9 R10 after end");
        instr(4'h2, 1'b1, 0, "R10 branch");
        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #20000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule